// File: doc/BRIEF.md
# Event Ring Producer with Completion Interrupt

This block sits on the device side of a host link and posts events into a circular ring held in host memory. An internal arbiter offers one event at a time: an 8-bit kind code and a 64-bit payload. The block packs the event into a 16-byte element and issues one memory-write request for the slot that its local read index points to. When the memory side acknowledges the write, the block advances that index with wraparound and pulses an interrupt line so that the host looks at the ring.

The host owns the other index. It reads events out of the ring and then writes its index forward through a register-write strobe. This returns the consumed slots to the producer. The producer advances the read index and the host advances the write index, which is the opposite of a work-submission ring. For that reason the tests for "full" and "nothing pending" are swapped compared with such a ring. While the ring is full, the arbiter is held off with a low ready signal.

Top module: `evt_ring_poster`

## Requirements
- R1: After reset the device read index is 0 and the local host index is DEPTH-1, so the ring holds no pending events (host index + 1 == read index). `irq` and `mem_wr_valid` are low and `req_ready` is high.
- R2: An accepted event is written at address `base_addr + read_index * 16`, computed modulo 2^ADDR_W. `base_addr` is sampled in the accept cycle.
- R3: The element word is packed as follows:
  - bits [127:120] hold the kind code;
  - bits [119:64] are zero;
  - bits [63:0] hold the payload.
  The kind codes are 8'h01 for transfer completion, 8'h02 for command completion and 8'h03 for state change.
- R4: `mem_wr_valid` rises in the cycle after acceptance. It stays high, with address and data unchanged, until the cycle in which `mem_wr_ack` is high.
- R5: In the cycle after the acknowledge, `dev_rp` reads the previous index plus one, modulo DEPTH.
- R6: `irq` is high for exactly one cycle, in the cycle after each acknowledge. Every posted event gives exactly one pulse.
- R7: When the read index equals the host index, the ring is full. In that state `req_ready` is low and no write is issued. A request held during this time is taken once the host frees a slot.
- R8: A host index write replaces the local host index. The free slot count is then (host index − read index) mod DEPTH, so the ring holds at most DEPTH-1 events starting from the reset state.
- R9: Only one write is in flight at a time. `req_ready` is low from acceptance through the acknowledge cycle.
- R10: A host index write while a write is in flight leaves that write's address and data unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| base_addr | input | ADDR_W | Ring base address in host memory |
| host_wp_we | input | 1 | Strobe: host writes its ring index |
| host_wp_val | input | RING_IDX_W | New host index value |
| req_valid | input | 1 | Event request offered |
| req_ready | output | 1 | Event request can be taken |
| req_kind | input | 8 | Event kind code |
| req_payload | input | 64 | Event payload |
| mem_wr_valid | output | 1 | Memory write request |
| mem_wr_addr | output | ADDR_W | Write byte address |
| mem_wr_data | output | 128 | Element word |
| mem_wr_ack | input | 1 | Memory write acknowledged |
| irq | output | 1 | One-cycle interrupt pulse per posted event |
| dev_rp | output | RING_IDX_W | Device read index (next slot to fill) |

## Verification
The bench fills the ring from reset and checks that exactly DEPTH-1 events fit. A design that tested for space with the transfer-ring rule would either overwrite an unread slot or stall one slot early. It then sweeps every host release size against every acknowledge delay, with bases near the top of the address space. This exposes index wraparound and address-carry mistakes, which would show up as a wrong slot address or a missing stall at full. Each event is also checked for an interrupt that comes too early, is missing or is doubled, and for an address or word that changes while the acknowledge is late. A host index write is made in the middle of a write, and a held request is made across the full condition. These catch a design that loses the held request or re-samples its address from the live index.

// File: rtl/evt_ring_pkg.sv
package evt_ring_pkg;

    localparam int ELEM_BYTES = 16;
    localparam int ELEM_SHIFT = $clog2(ELEM_BYTES);
    localparam int KIND_W     = 8;
    localparam int PAYLOAD_W  = 64;
    localparam int EVT_W      = ELEM_BYTES * 8;
    localparam int RSVD_W     = EVT_W - KIND_W - PAYLOAD_W;

    typedef enum logic [KIND_W-1:0] {
        EVK_XFER_DONE = 8'h01,
        EVK_CMD_DONE  = 8'h02,
        EVK_STATE_CHG = 8'h03
    } evt_kind_e;

    typedef struct packed {
        logic [KIND_W-1:0]    kind;
        logic [RSVD_W-1:0]    rsvd;
        logic [PAYLOAD_W-1:0] payload;
    } evt_word_t;

    typedef enum logic {
        SEQ_IDLE,
        SEQ_WRITE
    } seq_state_e;

    function automatic evt_word_t pack_event(input logic [KIND_W-1:0] k,
                                             input logic [PAYLOAD_W-1:0] p);
        evt_word_t w;
        w.kind    = k;
        w.rsvd    = '0;
        w.payload = p;
        return w;
    endfunction

endpackage

// File: rtl/evt_ring_ptrs.sv
module evt_ring_ptrs #(
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             adv,
    input  logic             host_wp_we,
    input  logic [IDX_W-1:0] host_wp_val,
    output logic [IDX_W-1:0] rp,
    output logic             ring_full
);

    logic [IDX_W-1:0] wp_q;
    logic [IDX_W-1:0] wp_plus1;
    logic             ring_idle;

    always_ff @(posedge clk) begin
        if (rst) begin
            rp   <= '0;
            wp_q <= '1;
        end else begin
            if (adv) begin
                rp <= rp + IDX_W'(1);
            end
            if (host_wp_we) begin
                wp_q <= host_wp_val;
            end
        end
    end

    assign wp_plus1  = wp_q + IDX_W'(1);
    assign ring_full = (rp == wp_q);
    assign ring_idle = (wp_plus1 == rp);

    AST_ADV_HAS_ROOM: assert property (@(posedge clk) disable iff (rst)
        adv |-> !ring_full) else $error("advance into full ring"); // R7

    AST_RESET_IDLE: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (ring_idle && rp == '0)) else $error("reset not idle"); // R1

endmodule

// File: rtl/evt_ring_fmt.sv
module evt_ring_fmt
    import evt_ring_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 4
) (
    input  logic [ADDR_W-1:0]    base_addr,
    input  logic [IDX_W-1:0]     rp,
    input  logic [KIND_W-1:0]    kind,
    input  logic [PAYLOAD_W-1:0] payload,
    output logic [ADDR_W-1:0]    slot_addr,
    output evt_word_t            slot_word
);

    localparam int OFFS_W = IDX_W + ELEM_SHIFT;

    logic [OFFS_W-1:0] offs;

    assign offs = {rp, {ELEM_SHIFT{1'b0}}};

    generate
        if (ADDR_W > OFFS_W) begin : g_wide
            assign slot_addr = base_addr + {{(ADDR_W-OFFS_W){1'b0}}, offs};
        end else begin : g_narrow
            assign slot_addr = base_addr + offs[ADDR_W-1:0];
        end
    endgenerate

    assign slot_word = pack_event(kind, payload);

endmodule

// File: rtl/evt_ring_seq.sv
module evt_ring_seq
    import evt_ring_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              ring_full,
    input  logic [ADDR_W-1:0] nxt_addr,
    input  evt_word_t         nxt_word,
    output logic              mem_wr_valid,
    output logic [ADDR_W-1:0] mem_wr_addr,
    output evt_word_t         mem_wr_data,
    input  logic              mem_wr_ack,
    output logic              adv,
    output logic              irq
);

    seq_state_e state_q;
    logic       accept;

    assign req_ready    = (state_q == SEQ_IDLE) && !ring_full;
    assign accept       = req_valid && req_ready;
    assign mem_wr_valid = (state_q == SEQ_WRITE);
    assign adv          = mem_wr_valid && mem_wr_ack;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= SEQ_IDLE;
            mem_wr_addr <= '0;
            mem_wr_data <= '0;
            irq         <= 1'b0;
        end else begin
            irq <= adv;
            case (state_q)
                SEQ_IDLE: begin
                    if (accept) begin
                        mem_wr_addr <= nxt_addr;
                        mem_wr_data <= nxt_word;
                        state_q     <= SEQ_WRITE;
                    end
                end
                SEQ_WRITE: begin
                    if (mem_wr_ack) begin
                        state_q <= SEQ_IDLE;
                    end
                end
                default: state_q <= SEQ_IDLE;
            endcase
        end
    end

    AST_HOLD_UNTIL_ACK: assert property (@(posedge clk) disable iff (rst)
        (mem_wr_valid && !mem_wr_ack) |=>
            (mem_wr_valid && $stable(mem_wr_addr) && $stable(mem_wr_data)))
        else $error("write dropped or changed before ack"); // R4

    AST_IRQ_FOLLOWS_ACK: assert property (@(posedge clk) disable iff (rst)
        (mem_wr_valid && mem_wr_ack) |=> irq) else $error("no irq after ack"); // R6

    AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        irq |=> !irq) else $error("irq wider than one cycle"); // R6

    AST_SINGLE_FLIGHT: assert property (@(posedge clk) disable iff (rst)
        mem_wr_valid |-> !req_ready) else $error("ready during write"); // R9

endmodule

// File: rtl/evt_ring_poster.sv
module evt_ring_poster
    import evt_ring_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int RING_IDX_W = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [ADDR_W-1:0]     base_addr,
    input  logic                  host_wp_we,
    input  logic [RING_IDX_W-1:0] host_wp_val,
    input  logic                  req_valid,
    output logic                  req_ready,
    input  logic [KIND_W-1:0]     req_kind,
    input  logic [PAYLOAD_W-1:0]  req_payload,
    output logic                  mem_wr_valid,
    output logic [ADDR_W-1:0]     mem_wr_addr,
    output logic [EVT_W-1:0]      mem_wr_data,
    input  logic                  mem_wr_ack,
    output logic                  irq,
    output logic [RING_IDX_W-1:0] dev_rp
);

    logic              adv;
    logic              ring_full;
    logic [ADDR_W-1:0] nxt_addr;
    evt_word_t         nxt_word;
    evt_word_t         wr_word;

    evt_ring_ptrs #(.IDX_W(RING_IDX_W)) ptrs_i (
        .clk         (clk),
        .rst         (rst),
        .adv         (adv),
        .host_wp_we  (host_wp_we),
        .host_wp_val (host_wp_val),
        .rp          (dev_rp),
        .ring_full   (ring_full)
    );

    evt_ring_fmt #(.ADDR_W(ADDR_W), .IDX_W(RING_IDX_W)) fmt_i (
        .base_addr (base_addr),
        .rp        (dev_rp),
        .kind      (req_kind),
        .payload   (req_payload),
        .slot_addr (nxt_addr),
        .slot_word (nxt_word)
    );

    evt_ring_seq #(.ADDR_W(ADDR_W)) seq_i (
        .clk          (clk),
        .rst          (rst),
        .req_valid    (req_valid),
        .req_ready    (req_ready),
        .ring_full    (ring_full),
        .nxt_addr     (nxt_addr),
        .nxt_word     (nxt_word),
        .mem_wr_valid (mem_wr_valid),
        .mem_wr_addr  (mem_wr_addr),
        .mem_wr_data  (wr_word),
        .mem_wr_ack   (mem_wr_ack),
        .adv          (adv),
        .irq          (irq)
    );

    assign mem_wr_data = wr_word;

    AST_IRQ_RP_STEP: assert property (@(posedge clk) disable iff (rst)
        irq |-> (dev_rp == RING_IDX_W'($past(dev_rp) + 1'b1)))
        else $error("index did not step with irq"); // R5

endmodule

// File: tb/evt_ring_poster_tb.sv
`timescale 1ns/1ps
module evt_ring_poster_tb_top;

    localparam int AW    = 32;
    localparam int IW    = 3;
    localparam int DEPTH = 1 << IW;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic [AW-1:0]  base_addr = 32'h8000_1000;
    logic           host_wp_we = 1'b0;
    logic [IW-1:0]  host_wp_val = '0;
    logic           req_valid = 1'b0;
    logic           req_ready;
    logic [7:0]     req_kind = 8'h01;
    logic [63:0]    req_payload = '0;
    logic           mem_wr_valid;
    logic [AW-1:0]  mem_wr_addr;
    logic [127:0]   mem_wr_data;
    logic           mem_wr_ack = 1'b0;
    logic           irq;
    logic [IW-1:0]  dev_rp;

    int errors = 0;
    int checks = 0;
    logic [IW-1:0] exp_rp = '0;
    logic [IW-1:0] exp_wp = '1;
    logic [AW-1:0] exp_addr;
    logic [127:0]  exp_data;

    always #2.5 clk = ~clk;

    evt_ring_poster #(.ADDR_W(AW), .RING_IDX_W(IW)) dut_i (
        .clk(clk), .rst(rst), .base_addr(base_addr),
        .host_wp_we(host_wp_we), .host_wp_val(host_wp_val),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_kind(req_kind), .req_payload(req_payload),
        .mem_wr_valid(mem_wr_valid), .mem_wr_addr(mem_wr_addr),
        .mem_wr_data(mem_wr_data), .mem_wr_ack(mem_wr_ack),
        .irq(irq), .dev_rp(dev_rp)
    );

    task automatic check(input logic ok, input string req,
                         input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic host_write(input logic [IW-1:0] v);
        host_wp_we  = 1'b1;
        host_wp_val = v;
        @(negedge clk);
        host_wp_we  = 1'b0;
        exp_wp      = v;
    endtask

    task automatic post_event(input logic [7:0] k, input logic [63:0] p,
                              input int delay, input logic mid_wp);
        req_kind    = k;
        req_payload = p;
        req_valid   = 1'b1;
        while (!req_ready) @(negedge clk);
        exp_addr = base_addr + AW'({exp_rp, 4'b0000});
        exp_data = {k, 56'h0, p};
        @(negedge clk);
        req_valid = 1'b0;
        check(mem_wr_valid == 1'b1, "R4 valid after accept", 128'(mem_wr_valid), 128'd1);
        check(mem_wr_addr == exp_addr, "R2 slot address", 128'(mem_wr_addr), 128'(exp_addr));
        check(mem_wr_data == exp_data, "R3 element word", mem_wr_data, exp_data);
        check(req_ready == 1'b0, "R9 busy while in flight", 128'(req_ready), 128'd0);
        for (int i = 0; i < delay; i++) begin
            if (mid_wp && i == 0) begin
                host_write(exp_wp + IW'(1));
            end else begin
                @(negedge clk);
            end
            check(mem_wr_valid && mem_wr_addr == exp_addr && mem_wr_data == exp_data,
                  mid_wp ? "R10 write unchanged by host index" : "R4 hold until ack",
                  mem_wr_data, exp_data);
            check(irq == 1'b0, "R6 no early irq", 128'(irq), 128'd0);
        end
        mem_wr_ack = 1'b1;
        @(negedge clk);
        mem_wr_ack = 1'b0;
        exp_rp = exp_rp + IW'(1);
        check(irq == 1'b1, "R6 irq after ack", 128'(irq), 128'd1);
        check(dev_rp == exp_rp, "R5 index step", 128'(dev_rp), 128'(exp_rp));
        check(mem_wr_valid == 1'b0, "R4 valid drops after ack", 128'(mem_wr_valid), 128'd0);
        @(negedge clk);
        check(irq == 1'b0, "R6 single-cycle irq", 128'(irq), 128'd0);
    endtask

    task automatic check_blocked(input int n, input string req);
        for (int i = 0; i < n; i++) begin
            check(req_ready == 1'b0 && mem_wr_valid == 1'b0, req,
                  128'({req_ready, mem_wr_valid}), 128'd0);
            @(negedge clk);
        end
    endtask

    task automatic fill_ring(input int d);
        int n = 0;
        while (IW'(exp_wp - exp_rp) != '0) begin
            post_event(8'h01 + 8'(n % 3), 64'hA5A5_0000_0000_0000 + 64'(n), d, 1'b0);
            n++;
        end
    endtask

    initial begin : watchdog
        #(200000 * 5);
        errors++;
        checks++;
        $display("FAIL watchdog expired act=running exp=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(dev_rp == '0, "R1 reset index", 128'(dev_rp), 128'd0);
        check(irq == 1'b0 && mem_wr_valid == 1'b0, "R1 reset outputs quiet",
              128'({irq, mem_wr_valid}), 128'd0);
        check(req_ready == 1'b1, "R1 reset ready", 128'(req_ready), 128'd1);

        // R8 capacity from reset is DEPTH-1
        for (int i = 0; i < DEPTH - 1; i++) begin
            post_event(8'h01 + 8'(i % 3), 64'h1111_0000_0000_0000 + 64'(i * 7), i % 3, 1'b0);
        end
        check(dev_rp == IW'(DEPTH - 1), "R8 capacity DEPTH-1", 128'(dev_rp), 128'(DEPTH - 1));
        check_blocked(4, "R7 full blocks requests");

        // R7 held request taken once host frees slots
        req_kind = 8'h03; req_payload = 64'hDEAD_BEEF_0000_0001; req_valid = 1'b1;
        check_blocked(3, "R7 held request waits");
        host_write(exp_wp + IW'(2));
        post_event(8'h03, 64'hDEAD_BEEF_0000_0001, 1, 1'b0);
        post_event(8'h02, 64'hDEAD_BEEF_0000_0002, 0, 1'b0);
        check_blocked(3, "R7 full again after release of two");

        // R10 host index write during an in-flight write
        host_write(exp_wp + IW'(1));
        post_event(8'h01, 64'h0123_4567_89AB_CDEF, 3, 1'b1);
        fill_ring(2);
        check_blocked(2, "R8 full after refill");

        // Sweep release sizes and ack delays, including address carry
        for (int k = 1; k < DEPTH; k++) begin
            for (int d = 0; d < 4; d++) begin
                base_addr = (k == DEPTH - 1) ? 32'hFFFF_FFC0 : (32'h1000_0000 * k + 32'h100 * d);
                host_write(exp_wp + IW'(k));
                for (int e = 0; e < k; e++) begin
                    post_event(8'h01 + 8'((e + d) % 3), {32'(k), 16'(d), 16'(e)}, (e + d) % 4, 1'b0);
                end
                check_blocked(1, "R8 free slots equal release size");
            end
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule